// File: doc/BRIEF.md
# Masked Program-Counter Match Trigger

This block watches the address of each retired instruction and compares it with a programmed trigger address. A programmable count of low-order address bits is left out of the comparison, so the trigger address stands for a naturally aligned window of 2^n bytes. A sense bit chooses whether the trigger fires when the program counter enters that window or when it leaves it.

When the trace controller has tracing running and has enabled address matching, the first qualifying instruction produces a one-cycle stop-trigger pulse and sets a sticky cause flag. The flag, and the ability to fire again, are restored only when tracing is switched off, which is a falling edge on the trace-enable input. To keep a trace running with no address stop, software sets the ignored-bit count to its maximum of 31 and leaves matching disabled.

Top module: `pc_match_trigger`

## Requirements
- R1: After reset `stop_trig` and `pc_cause` are 0, and `trig_pc_rd` and `mctl_rd` read 0.
- R2: A cycle with `wr_pc` high loads `wr_data` into the trigger address, visible on `trig_pc_rd` from the next cycle. A cycle with `wr_mctl` high loads the ignored-bit count from `wr_data[4:0]` and the sense bit from `wr_data[31]`; `mctl_rd` returns those fields in the same positions and 0 in bits 30:5.
- R3: With sense 0, an instruction whose address equals the trigger address in every bit from the ignored-bit count up to bit 31 fires the trigger; a difference in any such bit does not.
- R4: With sense 1, the trigger fires only when the address differs from the trigger address in at least one compared bit.
- R5: While `match_en` is 0 no address fires the trigger and `pc_cause` stays 0.
- R6: An address presented with `pc_valid` 0 is not evaluated and fires nothing.
- R7: A qualifying instruction in cycle t drives `stop_trig` high for exactly cycle t+1; later qualifying instructions produce no further pulse until the trigger is re-armed.
- R8: `pc_cause` rises together with `stop_trig`, stays high while `trace_en` stays high, and returns to 0 the cycle after `trace_en` falls; the trigger can then fire again.
- R9: With an ignored-bit count of 31 only bit 31 of the address takes part in the comparison.
- R10: While `trace_en` is 0 no address fires the trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_pc | input | 1 | Write strobe for the trigger address |
| wr_mctl | input | 1 | Write strobe for the match-control word |
| wr_data | input | 32 | Write data for either register |
| trace_en | input | 1 | Tracing running; a falling edge re-arms |
| match_en | input | 1 | Address matching may raise a stop |
| pc_valid | input | 1 | Retired-instruction strobe |
| pc | input | 32 | Address of the retired instruction |
| stop_trig | output | 1 | One-cycle stop-trigger pulse |
| pc_cause | output | 1 | Sticky flag: stop caused by address match |
| trig_pc_rd | output | 32 | Trigger address readback |
| mctl_rd | output | 32 | Match-control readback (sense bit 31, count bits 4:0) |

## Verification
The assertions watch on every cycle that a pulse lasts one cycle, never appears without tracing, matching and a valid instruction in the previous cycle, never repeats while the cause flag is set, and that the flag holds while tracing runs and clears after tracing stops. Whether a given address lands inside or outside a window for a given ignored-bit count and sense can only be shown by the bench's vectors, as can the readback field layout and re-firing after a re-arm.

// File: rtl/pc_match_trigger.sv
module pc_match_trigger #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_pc,
  input  logic            wr_mctl,
  input  logic [PC_W-1:0] wr_data,
  input  logic            trace_en,
  input  logic            match_en,
  input  logic            pc_valid,
  input  logic [PC_W-1:0] pc,
  output logic            stop_trig,
  output logic            pc_cause,
  output logic [PC_W-1:0] trig_pc_rd,
  output logic [PC_W-1:0] mctl_rd
);
  localparam int LEN_W = $clog2(PC_W);

  logic [PC_W-1:0]  trig_pc_q;
  logic [LEN_W-1:0] len_q;
  logic             sense_q;
  logic             en_q;
  logic             cause_q;
  logic             pulse_q;

  logic [PC_W-1:0] keep;
  logic            in_range;
  logic            fire;
  logic            rearm;

  assign keep     = {PC_W{1'b1}} << len_q;
  assign in_range = ((pc ^ trig_pc_q) & keep) == '0;
  assign fire     = pc_valid & trace_en & match_en & ~cause_q & (in_range ^ sense_q);
  assign rearm    = en_q & ~trace_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_pc_q <= '0;
      len_q     <= '0;
      sense_q   <= 1'b0;
    end else begin
      if (wr_pc) trig_pc_q <= wr_data;
      if (wr_mctl) begin
        len_q   <= wr_data[LEN_W-1:0];
        sense_q <= wr_data[PC_W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cause_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      en_q    <= trace_en;
      pulse_q <= fire;
      if (rearm)     cause_q <= 1'b0;
      else if (fire) cause_q <= 1'b1;
    end
  end

  assign stop_trig  = pulse_q;
  assign pc_cause   = cause_q;
  assign trig_pc_rd = trig_pc_q;
  assign mctl_rd    = {sense_q, {(PC_W-1-LEN_W){1'b0}}, len_q};
endmodule

// File: rtl/pc_match_trigger_chk.sv
module pc_match_trigger_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_pc,
  input logic [PC_W-1:0] wr_data,
  input logic            trace_en,
  input logic            match_en,
  input logic            pc_valid,
  input logic            stop_trig,
  input logic            pc_cause,
  input logic [PC_W-1:0] trig_pc_rd
);
  p_pc_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pc |=> trig_pc_rd == $past(wr_data));

  p_qualified_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_trig |-> $past(match_en));

  p_valid_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_trig |-> $past(pc_valid));

  p_trace_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_trig |-> $past(trace_en));

  p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_trig |=> !stop_trig);

  p_no_refire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_trig |-> !$past(pc_cause));

  p_cause_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_trig |-> pc_cause);

  p_cause_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_cause && trace_en) |=> pc_cause);

  p_cause_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trace_en) |=> !pc_cause);
endmodule

bind pc_match_trigger pc_match_trigger_chk #(.PC_W(PC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_pc(wr_pc), .wr_data(wr_data),
  .trace_en(trace_en), .match_en(match_en), .pc_valid(pc_valid),
  .stop_trig(stop_trig), .pc_cause(pc_cause), .trig_pc_rd(trig_pc_rd)
);

// File: tb/tb_pc_match_trigger.sv
`timescale 1ns/1ps
module tb_pc_match_trigger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_pc = 1'b0, wr_mctl = 1'b0;
  logic [31:0] wr_data = '0;
  logic        trace_en = 1'b0, match_en = 1'b0, pc_valid = 1'b0;
  logic [31:0] pc = '0;
  logic        stop_trig, pc_cause;
  logic [31:0] trig_pc_rd, mctl_rd;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pc_match_trigger dut (
    .clk(clk), .rst_n(rst_n), .wr_pc(wr_pc), .wr_mctl(wr_mctl), .wr_data(wr_data),
    .trace_en(trace_en), .match_en(match_en), .pc_valid(pc_valid), .pc(pc),
    .stop_trig(stop_trig), .pc_cause(pc_cause), .trig_pc_rd(trig_pc_rd), .mctl_rd(mctl_rd)
  );

  // {ignored-bit count[4:0], sense, trigger address, instruction address, expected fire}
  localparam logic [70:0] VEC [10] = '{
    {5'd0,  1'b0, 32'h0000_1000, 32'h0000_1000, 1'b1},
    {5'd0,  1'b0, 32'h0000_1000, 32'h0000_1004, 1'b0},
    {5'd4,  1'b0, 32'h0000_1000, 32'h0000_100F, 1'b1},
    {5'd4,  1'b0, 32'h0000_1000, 32'h0000_1010, 1'b0},
    {5'd8,  1'b1, 32'h2000_0000, 32'h2000_00FF, 1'b0},
    {5'd8,  1'b1, 32'h2000_0000, 32'h2000_0100, 1'b1},
    {5'd31, 1'b0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1},
    {5'd31, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0},
    {5'd31, 1'b1, 32'h0000_0000, 32'h8000_0000, 1'b1},
    {5'd16, 1'b0, 32'hABCD_0000, 32'hABCD_1234, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [4:0] len, input logic sense, input logic [31:0] tpc);
    @(negedge clk); wr_mctl = 1'b1; wr_data = {sense, 26'd0, len};
    @(negedge clk); wr_mctl = 1'b0; wr_pc = 1'b1; wr_data = tpc;
    @(negedge clk); wr_pc = 1'b0;
  endtask

  task automatic rearm();
    @(negedge clk); trace_en = 1'b0;
    @(negedge clk); trace_en = 1'b1;
  endtask

  // one instruction in the cycle after this negedge; outputs sampled one negedge later
  task automatic retire(input logic [31:0] addr, input logic vld);
    @(negedge clk); pc = addr; pc_valid = vld;
    @(negedge clk); pc_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 stop_trig", {31'd0, stop_trig}, 32'd0);
    check("R1 pc_cause", {31'd0, pc_cause}, 32'd0);
    check("R1 trig_pc_rd", trig_pc_rd, 32'd0);
    check("R1 mctl_rd", mctl_rd, 32'd0);
    rst_n = 1'b1;

    // R2 readback layout
    @(negedge clk); wr_mctl = 1'b1; wr_data = 32'hFFFF_FFFF;
    @(negedge clk); wr_mctl = 1'b0;
    check("R2 mctl_rd fields", mctl_rd, 32'h8000_001F);
    wr_pc = 1'b1; wr_data = 32'h1234_5678;
    @(negedge clk); wr_pc = 1'b0;
    check("R2 trig_pc_rd", trig_pc_rd, 32'h1234_5678);

    // R3 R4 R9 vector table
    match_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      cfg(VEC[i][70:66], VEC[i][65], VEC[i][64:33]);
      rearm();
      retire(VEC[i][32:1], 1'b1);
      check($sformatf("R3/R4/R9 vec %0d stop_trig", i), {31'd0, stop_trig}, {31'd0, VEC[i][0]});
      check($sformatf("R8 vec %0d pc_cause", i), {31'd0, pc_cause}, {31'd0, VEC[i][0]});
      @(negedge clk);
      check($sformatf("R7 vec %0d pulse width", i), {31'd0, stop_trig}, 32'd0);
    end

    // exact window, sense 0, count 4 around 0x40
    cfg(5'd4, 1'b0, 32'h0000_0040);
    rearm();

    // R5 matching disabled
    match_en = 1'b0;
    retire(32'h0000_0044, 1'b1);
    check("R5 stop_trig", {31'd0, stop_trig}, 32'd0);
    check("R5 pc_cause", {31'd0, pc_cause}, 32'd0);
    match_en = 1'b1;

    // R6 invalid strobe
    retire(32'h0000_0044, 1'b0);
    check("R6 stop_trig", {31'd0, stop_trig}, 32'd0);
    check("R6 pc_cause", {31'd0, pc_cause}, 32'd0);

    // R10 trace off
    @(negedge clk); trace_en = 1'b0;
    retire(32'h0000_0044, 1'b1);
    check("R10 stop_trig", {31'd0, stop_trig}, 32'd0);
    check("R10 pc_cause", {31'd0, pc_cause}, 32'd0);
    @(negedge clk); trace_en = 1'b1;

    // R7 first fire then no refire
    retire(32'h0000_0048, 1'b1);
    check("R7 first fire", {31'd0, stop_trig}, 32'd1);
    retire(32'h0000_004C, 1'b1);
    check("R7 no refire", {31'd0, stop_trig}, 32'd0);
    check("R8 cause held", {31'd0, pc_cause}, 32'd1);

    // R8 clear on trace_en fall, then fire again
    @(negedge clk); trace_en = 1'b0;
    @(negedge clk);
    check("R8 cause cleared", {31'd0, pc_cause}, 32'd0);
    trace_en = 1'b1;
    retire(32'h0000_0040, 1'b1);
    check("R8 fires after rearm", {31'd0, stop_trig}, 32'd1);
    check("R8 cause set again", {31'd0, pc_cause}, 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule